// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Read Buffer

This block keeps wall-clock time and calendar date as seven BCD bytes: seconds, minutes, hours, day of week, date, month (with a century flag in its top bit) and year. A free-running prescaler is advanced by a 32.768 kHz clock enable. Each time the prescaler wraps, the counters advance by one second and carry through the calendar. Month lengths, leap-year February, 12/24-hour hours and the century flag are all handled in the carry logic.

Software reaches the registers through a byte-wide port with a self-advancing pointer. Reads never see the live counters. They return bytes from a snapshot buffer, which is refreshed on a bus START strobe or when the pointer steps from the last register back to the first. A multi-byte read is therefore coherent even when a second boundary passes during the read.

Writes go to the live counters. A write to seconds also clears the prescaler, which restarts the current second at a known phase. The top bit of the prescaler drives a 1 Hz square wave.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read sec 00h, min 00h, hour 00h, day-of-week 01h, date 01h, month 01h, year 00h, and `sq_1hz` is low.
- R2: Seconds and minutes count in BCD from 00h to 59h. At 59h they return to 00h and carry into the next field.
- R3: Hours bit 6 = 0 selects 24-hour mode, where bits 5:0 count 00h..23h. The step from 23h to 00h advances the day.
- R4: Hours bit 6 = 1 selects 12-hour mode, where bit 5 is PM and bits 4:0 run 12h, 01h..11h. Going from 11h to 12h flips PM, and the day advances only when leaving 11 PM.
- R5: Day of week steps by one on each day advance and wraps from 07h to 01h.
- R6: Date wraps to 01h after 30h in months 04h, 06h, 09h and 11h, and after 31h in the other months. In February it wraps after 29h when the year value is a multiple of four, and after 28h otherwise. The month advances with each wrap.
- R7: The month wraps from 12h to 01h and advances the year. The year wraps from 99h to 00h, and that wrap toggles month bit 7.
- R8: Register addresses are 0 sec, 1 min, 2 hour, 3 day-of-week, 4 date, 5 month, 6 year. Each read or write steps the pointer by one, and it wraps from 6 to 0. `ptr_load` sets the pointer to `ptr_val`, and a value above 6 loads 0.
- R9: `rd_data` shows the snapshot byte at the pointer. The snapshot copies the live registers on `bus_start` or on a pointer step from 6 to 0, and at no other time.
- R10: Writing seconds loads the value and clears the prescaler. The next second advance comes 2^DIV_BITS ticks later.
- R11: `sq_1hz` is low for the first 2^(DIV_BITS-1) ticks of each second and high for the rest.
- R12: If a write falls in the same cycle as a second advance, the written field takes the written value and the other fields advance as usual. A seconds write in that cycle suppresses the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | 32.768 kHz clock enable |
| bus_start | input | 1 | START strobe; refreshes the snapshot |
| ptr_load | input | 1 | Load the address pointer |
| ptr_val | input | 3 | Pointer value to load |
| rd_en | input | 1 | Byte read; steps the pointer |
| wr_en | input | 1 | Byte write strobe (acknowledge); steps the pointer |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Snapshot byte at the pointer |
| sq_1hz | output | 1 | 1 Hz square wave |

## Verification
A register write and the once-per-second carry can land in the same clock cycle. The bench provokes this by counting prescaler ticks exactly, so that the write strobe to minutes (and in a second run, to seconds) lands on the tick that completes the second.

The result is judged from a fresh snapshot:
- Minutes case: the minutes byte must hold the written value while seconds have still rolled over.
- Seconds case: seconds must hold the written value, minutes must not move, and the next second must start a full period later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 7;
  localparam int PTR_W = $clog2(NREG);
  localparam logic [PTR_W-1:0] LAST_ADDR = PTR_W'(NREG - 1);
  localparam logic [PTR_W-1:0] ADDR_SEC  = 3'd0;
  localparam logic [PTR_W-1:0] ADDR_MIN  = 3'd1;
  localparam logic [PTR_W-1:0] ADDR_HOUR = 3'd2;
  localparam logic [PTR_W-1:0] ADDR_DOW  = 3'd3;
  localparam logic [PTR_W-1:0] ADDR_DATE = 3'd4;
  localparam logic [PTR_W-1:0] ADDR_MON  = 3'd5;
  localparam logic [PTR_W-1:0] ADDR_YEAR = 3'd6;

  // add one to a two-digit BCD byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year value (tens*10 + ones) divisible by four
  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] bin;
    bin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  // last date of a month, BCD
  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon[4:0])
      5'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // {day_carry, next hours byte} for both hour formats
  function automatic logic [8:0] hour_next(input logic [7:0] h);
    logic [7:0] nx;
    logic [7:0] hr;
    logic       cy;
    cy = 1'b0;
    if (h[6]) begin
      hr = {3'b000, h[4:0]};
      if (hr == 8'h12) nx = {2'b01, h[5], 5'h01};
      else if (hr == 8'h11) begin
        nx = {2'b01, ~h[5], 5'h12};
        cy = h[5];
      end else begin
        hr = bcd_inc(hr);
        nx = {2'b01, h[5], hr[4:0]};
      end
    end else begin
      hr = {2'b00, h[5:0]};
      if (hr == 8'h23) begin
        nx = 8'h00;
        cy = 1'b1;
      end else nx = bcd_inc(hr);
    end
    return {cy, nx};
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic sec_pulse,
  output logic sq
);
  localparam logic [DIV_BITS-1:0] TOP = '1;
  logic [DIV_BITS-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign sec_pulse = tick & ~clr & (cnt == TOP);
  assign sq        = cnt[DIV_BITS-1];
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sec_pulse,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NREG*8-1:0]     live_flat
);
  logic [7:0] sec, min, hour, dow, date, mon, year;
  logic [8:0] hr_res;
  logic       c_min, c_hr, c_day, c_mon, c_yr, yr_wrap;
  logic [7:0] mend, mon_low_n;

  always_comb begin
    c_min     = sec_pulse & (sec == 8'h59);
    c_hr      = c_min & (min == 8'h59);
    hr_res    = hour_next(hour);
    c_day     = c_hr & hr_res[8];
    mend      = month_end(mon, year);
    c_mon     = c_day & (date == mend);
    c_yr      = c_mon & (mon[4:0] == 5'h12);
    yr_wrap   = c_yr & (year == 8'h99);
    mon_low_n = (mon[4:0] == 5'h12) ? 8'h01 : bcd_inc({3'b000, mon[4:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; dow <= 8'h01;
      date <= 8'h01; mon <= 8'h01; year <= 8'h00;
    end else begin
      if (wr_en && wr_addr == ADDR_SEC) sec <= wr_data;
      else if (sec_pulse) sec <= (sec == 8'h59) ? 8'h00 : bcd_inc(sec);

      if (wr_en && wr_addr == ADDR_MIN) min <= wr_data;
      else if (c_min) min <= (min == 8'h59) ? 8'h00 : bcd_inc(min);

      if (wr_en && wr_addr == ADDR_HOUR) hour <= wr_data;
      else if (c_hr) hour <= hr_res[7:0];

      if (wr_en && wr_addr == ADDR_DOW) dow <= wr_data;
      else if (c_day) dow <= (dow == 8'h07) ? 8'h01 : bcd_inc(dow);

      if (wr_en && wr_addr == ADDR_DATE) date <= wr_data;
      else if (c_day) date <= (date == mend) ? 8'h01 : bcd_inc(date);

      if (wr_en && wr_addr == ADDR_MON) mon <= wr_data;
      else if (c_mon) mon <= {mon[7] ^ yr_wrap, 2'b00, mon_low_n[4:0]};

      if (wr_en && wr_addr == ADDR_YEAR) year <= wr_data;
      else if (c_yr) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  assign live_flat = {year, mon, date, dow, hour, min, sec};
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic              step,
  input  logic [NREG*8-1:0] live_flat,
  output logic [PTR_W-1:0]  ptr,
  output logic              snap_load,
  output logic [NREG*8-1:0] snap_flat,
  output logic [7:0]        rd_data
);
  logic [7:0] snap [NREG];

  assign snap_load = bus_start | (step & ~ptr_load & (ptr == LAST_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ptr_load) ptr <= (ptr_val > LAST_ADDR) ? '0 : ptr_val;
    else if (step)     ptr <= (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         snap[i] <= 8'h00;
      else if (snap_load) snap[i] <= live_flat[i*8 +: 8];
    end
    assign snap_flat[i*8 +: 8] = snap[i];
  end

  assign rd_data = snap[ptr];
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       bus_start,
  input  logic       ptr_load,
  input  logic [2:0] ptr_val,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sq_1hz
);
  logic              sec_pulse;
  logic              chain_clr;
  logic              snap_load;
  logic [PTR_W-1:0]  ptr;
  logic [NREG*8-1:0] live_flat;
  logic [NREG*8-1:0] snap_flat;

  assign chain_clr = wr_en & (ptr == ADDR_SEC);

  rtc_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .clr(chain_clr),
    .sec_pulse(sec_pulse), .sq(sq_1hz)
  );

  rtc_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .wr_en(wr_en),
    .wr_addr(ptr), .wr_data(wr_data), .live_flat(live_flat)
  );

  rtc_shadow u_shd (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .ptr_load(ptr_load),
    .ptr_val(ptr_val), .step(rd_en | wr_en), .live_flat(live_flat),
    .ptr(ptr), .snap_load(snap_load), .snap_flat(snap_flat), .rd_data(rd_data)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic        ptr_load,
  input logic [7:0]  wr_data,
  input logic [2:0]  ptr,
  input logic        sec_pulse,
  input logic        chain_clr,
  input logic        snap_load,
  input logic [55:0] live_flat,
  input logic [55:0] snap_flat,
  input logic        sq_1hz
);
  a_r10_sec_write: assert property (@(posedge clk) disable iff (!rst_n)
    chain_clr |=> live_flat[7:0] == $past(wr_data));

  a_r11_sq_low_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    chain_clr |=> !sq_1hz);

  a_r9_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> snap_flat == $past(live_flat));

  a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(snap_flat));

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 3'd6);

  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_load && (rd_en || wr_en) && ptr == 3'd6) |=> ptr == 3'd0);

  a_r2_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !chain_clr) |=> $stable(live_flat[7:0]));
endmodule

bind bcd_rtc rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .ptr_load(ptr_load),
  .wr_data(wr_data), .ptr(ptr), .sec_pulse(sec_pulse), .chain_clr(chain_clr),
  .snap_load(snap_load), .live_flat(live_flat), .snap_flat(snap_flat),
  .sq_1hz(sq_1hz)
);

// File: tb/bcd_rtc_tb.sv
`timescale 1ns/1ps
module bcd_rtc_tb;
  localparam int DIV = 4;
  localparam int PER = 1 << DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0, bus_start = 1'b0, ptr_load = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] ptr_val = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sq_1hz;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  bcd_rtc #(.DIV_BITS(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_start(bus_start),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sq_1hz(sq_1hz)
  );

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (rd_data !== e) begin
        failures++;
        $display("FAIL %s act=%h exp=%h", t, rd_data, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_ptr(input logic [2:0] p);
    ptr_load = 1'b1; ptr_val = p; step(); ptr_load = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b; step(); wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, yr);
    set_ptr(3'd0);
    wr(s); wr(m); wr(h); wr(dw); wr(dt); wr(mo); wr(yr);
  endtask

  task automatic snap();
    bus_start = 1'b1; ptr_load = 1'b1; ptr_val = 3'd0; step();
    bus_start = 1'b0; ptr_load = 1'b0;
  endtask

  // driver: pushes the expectation, then issues the read
  task automatic rd(input logic [7:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic read_all(input logic [7:0] s, m, h, dw, dt, mo, yr, input string tag);
    snap();
    rd(s, {tag, " sec"}); rd(m, {tag, " min"}); rd(h, {tag, " hour"});
    rd(dw, {tag, " dow"}); rd(dt, {tag, " date"}); rd(mo, {tag, " month"});
    rd(yr, {tag, " year"});
  endtask

  task automatic ticks(input int n);
    tick_32k = 1'b1; repeat (n) step(); tick_32k = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    check(sq_1hz == 1'b0, "R1 sq after reset", sq_1hz, 0);
    read_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 reset");

    // R3 R5 R6: leap February, 24-hour midnight, dow 7 -> 1
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h29, 8'h02, 8'h24, "R3/R5/R6 leap");

    // R6 ordinary February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23, "R6 feb28");

    // R6 thirty-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h25, "R6 apr30");

    // R6 thirty-one-day month does not wrap at 30
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h25);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h00, 8'h02, 8'h31, 8'h01, 8'h25, "R6 jan30");

    // R7 year wrap toggles century both ways
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h81, 8'h00, "R7 century set");
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h92, 8'h99);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, "R7 century clear");

    // R4 12-hour: 11 AM -> 12 PM, 11 PM -> 12 AM with day advance, 12 -> 1
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h25);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h72, 8'h03, 8'h15, 8'h06, 8'h25, "R4 noon");
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h25);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h52, 8'h04, 8'h16, 8'h06, 8'h25, "R4 midnight");
    set_time(8'h59, 8'h59, 8'h52, 8'h03, 8'h15, 8'h06, 8'h25);
    ticks(PER);
    read_all(8'h00, 8'h00, 8'h41, 8'h03, 8'h15, 8'h06, 8'h25, "R4 12to1");

    // R2 BCD digit carry and minute carry
    set_time(8'h29, 8'h09, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(PER);
    read_all(8'h30, 8'h09, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00, "R2 digit");
    set_time(8'h59, 8'h09, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(PER);
    read_all(8'h00, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00, "R2 minute");

    // R9 snapshot holds while time advances; START refreshes
    set_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h03, 8'h04, 8'h05);
    snap();
    rd(8'h10, "R9 first");
    set_ptr(3'd0);
    ticks(PER);
    rd(8'h10, "R9 held");
    snap();
    rd(8'h11, "R9 start refresh");

    // R8 R9 wrap refresh
    snap();
    rd(8'h11, "R8 p0"); rd(8'h20, "R8 p1"); rd(8'h08, "R8 p2");
    rd(8'h02, "R8 p3"); rd(8'h03, "R8 p4"); rd(8'h04, "R8 p5");
    ticks(PER);
    rd(8'h05, "R8 p6 old snapshot");
    rd(8'h12, "R9 wrap refresh");
    set_ptr(3'd4);
    rd(8'h03, "R8 load 4");
    set_ptr(3'd7);
    rd(8'h12, "R8 load 7 gives 0");

    // R10 R11 seconds write clears the prescaler
    ticks(10);
    set_ptr(3'd0);
    wr(8'h30);
    ticks(PER/2 - 1);
    check(sq_1hz == 1'b0, "R11 sq first half", sq_1hz, 0);
    ticks(1);
    check(sq_1hz == 1'b1, "R11 sq second half", sq_1hz, 1);
    ticks(PER/2 - 1);
    snap();
    rd(8'h30, "R10 no early advance");
    ticks(1);
    snap();
    rd(8'h31, "R10 advance after full period");

    // R12 write to minutes coinciding with the second carry
    set_time(8'h59, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    set_ptr(3'd1);
    ticks(PER - 1);
    tick_32k = 1'b1; wr_en = 1'b1; wr_data = 8'h20; step();
    tick_32k = 1'b0; wr_en = 1'b0;
    snap();
    rd(8'h00, "R12 sec rolled"); rd(8'h20, "R12 min written"); rd(8'h05, "R12 hour");

    // R12 seconds write coinciding with the carry suppresses it
    set_time(8'h59, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    set_ptr(3'd0);
    ticks(PER - 1);
    tick_32k = 1'b1; wr_en = 1'b1; wr_data = 8'h05; step();
    tick_32k = 1'b0; wr_en = 1'b0;
    ticks(PER - 1);
    snap();
    rd(8'h05, "R12 sec written"); rd(8'h10, "R12 min no carry");

    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule